// File: doc/BRIEF.md
# Bus-Master IDE DMA Channel Registers

This block holds the host-visible control and status registers of one bus-master IDE DMA channel. Software reaches it through an eight-byte register window. Offset 0 is a command byte that holds a start bit and a transfer direction bit. Offset 2 is a status byte. Offset 4 is a 32-bit pointer to the descriptor table. Offsets 1, 3, 5, 6 and 7 are left for vendor use. They read as zero and writes to them are dropped. Register reads are combinational from the current register contents. Writes take effect at the next rising clock edge.

A transfer engine outside this block fetches the descriptors and moves the data. This block gives that engine three things: the start level, the direction, and the dword-aligned table base. It takes back an end-of-table pulse and an error pulse from the engine, and an interrupt pulse from the drive. From these it keeps the status flags that software polls.

The channel sequencer has three states:
- `CH_IDLE`: start is clear.
  - go: a command write with the start bit set moves it to `CH_RUN`.
- `CH_RUN`: the status active bit reads 1.
  - stop: a command write with the start bit clear returns to `CH_IDLE`. This takes priority.
  - end: an engine done or error pulse moves it to `CH_HALT`.
- `CH_HALT`: the transfer has ended but start is still set.
  - release: a command write with the start bit clear returns to `CH_IDLE`.
  - A second write of start=1 in this state does not restart the channel.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command byte, the status byte and the table pointer all read 0, and the channel is in `CH_IDLE`.
- R2: The command byte at offset 0 has two bits: bit 0 (start) and bit 3 (1 = drive to memory, 0 = memory to drive). `xfer_start` and `xfer_to_mem` follow these bits. All other command bits read 0.
- R3: Status bit 0 (active) reads 1 from the cycle after a command write raises start from 0 to 1. Writing start=1 again while start is already set does not re-enter `CH_RUN`.
- R4: In `CH_RUN`, an `eng_done` or `eng_error` pulse clears the active bit on the next cycle. The start bit stays set.
- R5: A command write with bit 0 clear stops the channel. On the next cycle both active and start read 0.
- R6: A command write made while active changes only the start bit. The direction bit keeps its value.
- R7: Status bit 1 (error) sets on `eng_error`. Status bit 2 (interrupt) sets on `drive_irq`. A set and a clear in the same cycle leave the bit set.
- R8: A status write with a 1 in bit 1 or bit 2 clears that bit. A 0 in that position leaves the bit unchanged.
- R9: Status bits 3 and 4 (hold flags) and bits 5 and 6 (drive 0 and drive 1 DMA-capable flags) are plain read/write. Writes to bit 0 and bit 7 are ignored, and bit 7 reads 0.
- R10: The table pointer at offset 4 takes a 32-bit write with bits [1:0] forced to 0. It reads back the stored value and drives `table_base`.
- R11: `xfer_ok` is 1 exactly when status bits [2:0] equal 100b, that is interrupt set, error clear and not active.
- R12: `wait_hold` is 1 exactly when status bits 3 and 4 are both set.
- R13: Offsets 1, 3, 5, 6 and 7 read 0. Writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Byte offset in the register window |
| host_wdata | input | 32 | Write data; the low byte is used for the command and status bytes |
| host_rdata | output | 32 | Read data for `host_addr`, zero-extended |
| eng_done | input | 1 | End-of-table pulse from the engine |
| eng_error | input | 1 | Error pulse from the engine |
| drive_irq | input | 1 | Interrupt pulse from the drive |
| xfer_start | output | 1 | Start bit to the engine |
| xfer_to_mem | output | 1 | Direction to the engine; 1 = drive to memory |
| table_base | output | 32 | Dword-aligned descriptor table base |
| xfer_active | output | 1 | Status active bit |
| xfer_ok | output | 1 | Status shows a good completion |
| wait_hold | output | 1 | Both hold flags set |

## Verification
On every cycle the assertions check the following:
- `CH_RUN` is never held without start.
- An end or error pulse in `CH_RUN` halts the channel unless a stop arrives in the same cycle.
- The direction stays frozen across command writes made while active.
- Error and interrupt sets win over a same-cycle clear.
- A write-one clear takes effect when no new event collides with it.

Some cases need the bench's scenarios to show them:
- No restart when start is written again in `CH_HALT`.
- Pointer alignment.
- Masking of the read-only and reserved status bits.
- Silence of the vendor offsets.
- The exact status byte values that `xfer_ok` and `wait_hold` are decoded from.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HALT = 2'd2
    } ch_state_e;

    localparam int unsigned OFS_CMD  = 0;
    localparam int unsigned OFS_STAT = 2;
    localparam int unsigned OFS_PTR  = 4;

    localparam int unsigned CMD_GO    = 0;
    localparam int unsigned CMD_TOMEM = 3;

    localparam int unsigned ST_ERR    = 1;
    localparam int unsigned ST_IRQ    = 2;
    localparam int unsigned ST_HOLD   = 3;
    localparam int unsigned ST_CAP    = 5;
    localparam int unsigned NUM_HOLD  = 2;
    localparam int unsigned NUM_DRIVES = 2;
endpackage

// File: rtl/bmdma_cmd_fsm.sv
module bmdma_cmd_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic wr_go,
    input  logic wr_tomem,
    input  logic eng_done,
    input  logic eng_error,
    output logic go,
    output logic to_mem,
    output logic active
);
    ch_state_e state, nxt;
    logic stop_wr;

    assign stop_wr = cmd_we && !wr_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: if (cmd_we && wr_go) nxt = CH_RUN;
            CH_RUN: begin
                if (stop_wr)                     nxt = CH_IDLE;
                else if (eng_done || eng_error)  nxt = CH_HALT;
            end
            CH_HALT: if (stop_wr) nxt = CH_IDLE;
            default: nxt = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go     <= 1'b0;
            to_mem <= 1'b0;
        end else if (cmd_we) begin
            go <= wr_go;
            if (state != CH_RUN) to_mem <= wr_tomem;
        end
    end

    always_comb begin
        active = (state == CH_RUN);
    end

    assert_run_has_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN) |-> go);

    assert_end_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && (eng_done || eng_error) && !stop_wr) |=> (state == CH_HALT && go));

    assert_stop_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (state == CH_IDLE && !go));

    assert_dir_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && cmd_we) |=> $stable(to_mem));
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_we,
    input  logic [6:1] st_wbits,
    input  logic       eng_error,
    input  logic       drive_irq,
    input  logic       active,
    output logic [7:0] st_byte
);
    logic                  err_q, irq_q;
    logic [NUM_HOLD-1:0]   hold_q;
    logic [NUM_DRIVES-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (eng_error)                     err_q <= 1'b1;
            else if (st_we && st_wbits[ST_ERR]) err_q <= 1'b0;
            if (drive_irq)                     irq_q <= 1'b1;
            else if (st_we && st_wbits[ST_IRQ]) irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (st_we) hold_q <= st_wbits[ST_HOLD +: NUM_HOLD];
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cap_q[g] <= 1'b0;
            else if (st_we) cap_q[g] <= st_wbits[ST_CAP + g];
        end
    end

    always_comb begin
        st_byte = {1'b0, cap_q, hold_q, irq_q, err_q, active};
    end

    assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_error |=> st_byte[ST_ERR]);

    assert_irq_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_irq |=> st_byte[ST_IRQ]);

    assert_irq_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wbits[ST_IRQ] && !drive_irq) |=> !st_byte[ST_IRQ]);

    assert_err_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wbits[ST_ERR] && !eng_error) |=> !st_byte[ST_ERR]);
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
    parameter int unsigned PTR_W = 32,
    parameter int unsigned ALIGN = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ptr_we,
    input  logic [PTR_W-1:ALIGN]   ptr_wdata,
    output logic [PTR_W-1:0]       ptr_q
);
    logic [PTR_W-1:ALIGN] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_q <= '0;
        else if (ptr_we) hi_q <= ptr_wdata;
    end

    assign ptr_q = {hi_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned ALIGN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_done,
    input  logic              eng_error,
    input  logic              drive_irq,
    output logic              xfer_start,
    output logic              xfer_to_mem,
    output logic [PTR_W-1:0]  table_base,
    output logic              xfer_active,
    output logic              xfer_ok,
    output logic              wait_hold
);
    logic       cmd_we, st_we, ptr_we;
    logic [7:0] st_byte, cmd_byte;

    assign cmd_we = host_we && (host_addr == ADDR_W'(OFS_CMD));
    assign st_we  = host_we && (host_addr == ADDR_W'(OFS_STAT));
    assign ptr_we = host_we && (host_addr == ADDR_W'(OFS_PTR));

    bmdma_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .wr_go     (host_wdata[CMD_GO]),
        .wr_tomem  (host_wdata[CMD_TOMEM]),
        .eng_done  (eng_done),
        .eng_error (eng_error),
        .go        (xfer_start),
        .to_mem    (xfer_to_mem),
        .active    (xfer_active)
    );

    bmdma_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_we     (st_we),
        .st_wbits  (host_wdata[6:1]),
        .eng_error (eng_error),
        .drive_irq (drive_irq),
        .active    (xfer_active),
        .st_byte   (st_byte)
    );

    bmdma_ptr #(.PTR_W(PTR_W), .ALIGN(ALIGN)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we    (ptr_we),
        .ptr_wdata (host_wdata[PTR_W-1:ALIGN]),
        .ptr_q     (table_base)
    );

    always_comb begin
        cmd_byte            = '0;
        cmd_byte[CMD_GO]    = xfer_start;
        cmd_byte[CMD_TOMEM] = xfer_to_mem;
    end

    always_comb begin
        case (host_addr)
            ADDR_W'(OFS_CMD):  host_rdata = DATA_W'(cmd_byte);
            ADDR_W'(OFS_STAT): host_rdata = DATA_W'(st_byte);
            ADDR_W'(OFS_PTR):  host_rdata = DATA_W'(table_base);
            default:           host_rdata = '0;
        endcase
    end

    assign xfer_ok   = (st_byte[2:0] == 3'b100);
    assign wait_hold = st_byte[ST_HOLD] && st_byte[ST_HOLD+1];
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_done = 1'b0, eng_error = 1'b0, drive_irq = 1'b0;
    logic        xfer_start, xfer_to_mem, xfer_active, xfer_ok, wait_hold;
    logic [31:0] table_base;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    bmdma_regs uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_done(eng_done), .eng_error(eng_error), .drive_irq(drive_irq),
        .xfer_start(xfer_start), .xfer_to_mem(xfer_to_mem), .table_base(table_base),
        .xfer_active(xfer_active), .xfer_ok(xfer_ok), .wait_hold(wait_hold)
    );

    // behavioural reference: 0 idle, 1 running, 2 halted
    int          m_st = 0;
    logic        m_go = 0, m_dir = 0, m_err = 0, m_irq = 0;
    logic [1:0]  m_hold = 0, m_cap = 0;
    logic [31:0] m_ptr = 0;

    function automatic logic [7:0] m_status();
        return {1'b0, m_cap, m_hold, m_irq, m_err, (m_st == 1)};
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_dir, 2'b00, m_go};
            3'd2: return {24'd0, m_status()};
            3'd4: return m_ptr;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_go = 0; m_dir = 0; m_err = 0; m_irq = 0;
            m_hold = 0; m_cap = 0; m_ptr = 0;
        end else begin
            bit cw, sw, pw, stop;
            cw = host_we && host_addr == 3'd0;
            sw = host_we && host_addr == 3'd2;
            pw = host_we && host_addr == 3'd4;
            stop = cw && !host_wdata[0];
            if (cw) begin
                if (m_st != 1) m_dir = host_wdata[3];
                m_go = host_wdata[0];
            end
            case (m_st)
                0: if (cw && host_wdata[0]) m_st = 1;
                1: if (stop) m_st = 0; else if (eng_done || eng_error) m_st = 2;
                default: if (stop) m_st = 0;
            endcase
            if (eng_error) m_err = 1; else if (sw && host_wdata[1]) m_err = 0;
            if (drive_irq) m_irq = 1; else if (sw && host_wdata[2]) m_irq = 0;
            if (sw) begin m_hold = host_wdata[4:3]; m_cap = host_wdata[6:5]; end
            if (pw) m_ptr = host_wdata & ~32'd3;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !finished) begin
            string rtag;
            check(xfer_start == m_go, "R2 start", 32'(xfer_start), 32'(m_go));
            check(xfer_to_mem == m_dir, "R6 direction", 32'(xfer_to_mem), 32'(m_dir));
            check(xfer_active == (m_st == 1), "R3 active", 32'(xfer_active), 32'(m_st == 1));
            check(table_base == m_ptr, "R10 table_base", table_base, m_ptr);
            check(xfer_ok == (m_status() [2:0] == 3'b100), "R11 xfer_ok", 32'(xfer_ok), 32'(m_status() [2:0] == 3'b100));
            check(wait_hold == (&m_hold), "R12 wait_hold", 32'(wait_hold), 32'(&m_hold));
            case (host_addr)
                3'd0: rtag = "R2 read";
                3'd2: rtag = "R8 read";
                3'd4: rtag = "R10 read";
                default: rtag = "R13 read";
            endcase
            check(host_rdata == m_read(host_addr), rtag, host_rdata, m_read(host_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_we = 0; host_wdata = '0;
    endtask

    task automatic pulse(input bit d, input bit e, input bit i);
        @(negedge clk); eng_done = d; eng_error = e; drive_irq = i;
        @(negedge clk); eng_done = 0; eng_error = 0; drive_irq = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); host_addr = a;
        @(posedge clk); #(CLK_P/4);
        check(host_rdata == exp, tag, host_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // r1_ reset values observed while reset is held
        check(host_rdata == 0 && !xfer_start && !xfer_active && table_base == 0, "R1 reset outputs", host_rdata, 0);
        @(negedge clk); rst_n = 1;
        rd_chk(3'd0, 32'h0, "R1 command after reset");
        rd_chk(3'd2, 32'h0, "R1 status after reset");
        rd_chk(3'd4, 32'h0, "R1 pointer after reset");

        wr(3'd4, 32'h1234_5677);
        rd_chk(3'd4, 32'h1234_5674, "R10 pointer alignment");

        wr(3'd0, 32'h0000_00F9);
        rd_chk(3'd0, 32'h09, "R2 command bits");
        rd_chk(3'd2, 32'h01, "R3 active after start");
        check(xfer_to_mem == 1, "R2 direction to memory", 32'(xfer_to_mem), 1);

        wr(3'd0, 32'h01);
        rd_chk(3'd0, 32'h09, "R6 direction kept while active");

        pulse(1, 0, 0);
        rd_chk(3'd2, 32'h00, "R4 done clears active");
        rd_chk(3'd0, 32'h09, "R4 start kept after done");

        pulse(0, 0, 1);
        rd_chk(3'd2, 32'h04, "R7 irq sets");
        check(xfer_ok == 1, "R11 good completion", 32'(xfer_ok), 1);

        wr(3'd0, 32'h09);
        rd_chk(3'd2, 32'h04, "R3 no restart from halt");

        wr(3'd2, 32'h04);
        rd_chk(3'd2, 32'h00, "R8 irq write-one clear");

        wr(3'd0, 32'h00);
        wr(3'd0, 32'h01);
        rd_chk(3'd0, 32'h01, "R2 direction to drive");
        pulse(0, 1, 0);
        rd_chk(3'd2, 32'h02, "R4 error halts, R7 error sets");
        check(xfer_ok == 0, "R11 error is not good", 32'(xfer_ok), 0);

        wr(3'd2, 32'h00);
        rd_chk(3'd2, 32'h02, "R8 zero leaves error");

        @(negedge clk); host_we = 1; host_addr = 3'd2; host_wdata = 32'h02; eng_error = 1;
        @(negedge clk); host_we = 0; eng_error = 0;
        rd_chk(3'd2, 32'h02, "R7 set beats clear");

        wr(3'd2, 32'hFF);
        rd_chk(3'd2, 32'h78, "R9 rw bits, bit0 and bit7 ignored");
        check(wait_hold == 1, "R12 hold both set", 32'(wait_hold), 1);
        wr(3'd2, 32'h08);
        rd_chk(3'd2, 32'h08, "R9 rw bits rewritten");
        check(wait_hold == 0, "R12 one hold bit", 32'(wait_hold), 0);

        wr(3'd0, 32'h00);
        wr(3'd0, 32'h01);
        rd_chk(3'd2, 32'h09, "R3 active again");
        wr(3'd0, 32'h00);
        rd_chk(3'd2, 32'h08, "R5 stop clears active");
        rd_chk(3'd0, 32'h00, "R5 stop clears start");

        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h0, "R13 offset 1 reads zero");
        rd_chk(3'd3, 32'h0, "R13 offset 3 reads zero");
        rd_chk(3'd0, 32'h0, "R13 command untouched");
        rd_chk(3'd2, 32'h08, "R13 status untouched");
        rd_chk(3'd4, 32'h1234_5674, "R13 pointer untouched");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule